// File: doc/BRIEF.md
# Flash Command Decoder and Read-Mode Selector

This block sits between the host bus and the internals of a 16-bit parallel NOR-style flash device. It decodes bus write cycles into commands and keeps track of the current read mode: array, status, identifier or query table. It starts program, erase and lock operations by handing a one-cycle request to an external write state machine. It also keeps an 8-bit status register. The ready bit of that register follows the state machine directly. The error bits are sticky: they are set by strobes from the state machine and stay set until a clear command or a reset.

In array mode, read data comes from the array through the `array_data` input. In the other modes the block drives the data bus itself. In status mode it drives a latched copy of the status register. That copy is refreshed according to the selected read style. In asynchronous reads it is refreshed when the first of chip-enable and output-enable falls. In synchronous burst reads it is refreshed only when chip-enable or address-valid falls. In identifier mode it drives fixed codes chosen by parameters. In query mode it drives a small computed table.

Top module: `flash_cui`

## Requirements
- R1: After reset the read mode is array (`read_mode` = 0) and `dq_out` equals `array_data`.
- R2: Command byte 0x70, written at any address, selects status mode (`read_mode` = 1). In that mode `dq_out[15:8]` is 0x00 and `dq_out[7:0]` is the latched status. Status bits 6, 2 and 0 always read 0.
- R3: A setup byte starts a two-cycle command: 0x40 or 0x10 for program, 0x20 for erase, 0x60 for lock. The next bus write is the data cycle. It raises `op_start` for exactly one cycle, with `op_kind` set to 0 for program, 1 for erase or 2 for lock. It also selects status mode. Setup bytes written while `wsm_busy` is high are ignored.
- R4: If `vpp_ok` is low on the data cycle of a program or erase, no operation starts. Instead, status bit 3 is set and status mode is selected.
- R5: Status bit 7 is 1 when `wsm_busy` is low and 0 when it is high.
- R6: Four strobes set sticky status bits: `wsm_err_erase` sets bit 5, `wsm_err_prog` sets bit 4, `wsm_err_vpp` sets bit 3 and `wsm_err_lock` sets bit 1. These bits are cleared only by command 0x50 or by reset. Command 0x50 works whatever the level of `vpp_ok` and leaves the read mode unchanged.
- R7: With `burst_mode` low, the status copy is captured when the first of `ce_n` and `oe_n` falls while both were high. A later fall of the other strobe does not recapture it.
- R8: With `burst_mode` high, the status copy is captured only on a fall of `ce_n` or `adv_n`. Otherwise the status copy holds its value even while the status bits change.
- R9: Command 0xFF selects array mode. If it is written while `wsm_busy` is high, it is held pending and takes effect in the cycle after `wsm_busy` goes low.
- R10: Command 0x90 selects identifier mode (`read_mode` = 2). Address 0 reads `MFR_CODE`. Address 1 reads the device code: 0x8960 (top-boot) or 0x8961 (bottom-boot), plus 2 for the larger density, or 0x8999/0x899A for the uniform-block arrangement. Other addresses read 0.
- R11: Command 0x98 selects query mode (`read_mode` = 3). Addresses 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059. Address 0x27 reads 26 plus the density flag. Other addresses read 0.
- R12: A bus write whose byte is not a known command, outside a data cycle, leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | One-cycle bus write strobe |
| addr | input | AW | Bus address (low 8 bits index the identifier and query tables) |
| wdata | input | 16 | Bus write data (command in bits 7:0) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid, active low |
| burst_mode | input | 1 | 1 selects synchronous burst read rules |
| vpp_ok | input | 1 | Programming voltage is adequate |
| array_data | input | 16 | Read data from the array |
| wsm_busy | input | 1 | The write state machine is busy |
| wsm_err_erase | input | 1 | Erase error strobe |
| wsm_err_prog | input | 1 | Program error strobe |
| wsm_err_vpp | input | 1 | Voltage error strobe |
| wsm_err_lock | input | 1 | Locked-block error strobe |
| dq_out | output | 16 | Read data |
| read_mode | output | 2 | 0 array, 1 status, 2 identifier, 3 query |
| op_start | output | 1 | One-cycle operation request |
| op_kind | output | 2 | 0 program, 1 erase, 2 lock |
| op_addr | output | AW | Address of the data cycle |
| op_data | output | 16 | Data of the data cycle |

## Verification
The assertions assume three things about the inputs. `bus_we` is a single-cycle pulse. `wsm_busy` rises only after an operation has been requested. The read strobes and `burst_mode` are synchronous to `clk`. The stimulus changes every input on the falling clock edge and holds it for whole cycles. It keeps `burst_mode` steady across each strobe sequence. It raises `wsm_busy` only when no data cycle is pending. Every error strobe lasts exactly one cycle.

// File: rtl/flash_cui.sv
module flash_cui #(
  parameter int          AW         = 24,
  parameter bit          DENSITY_1G = 1'b1,
  parameter logic [1:0]  BLOCK_ARR  = 2'd0,
  parameter logic [15:0] MFR_CODE   = 16'h0089
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          adv_n,
  input  logic          burst_mode,
  input  logic          vpp_ok,
  input  logic [15:0]   array_data,
  input  logic          wsm_busy,
  input  logic          wsm_err_erase,
  input  logic          wsm_err_prog,
  input  logic          wsm_err_vpp,
  input  logic          wsm_err_lock,
  output logic [15:0]   dq_out,
  output logic [1:0]    read_mode,
  output logic          op_start,
  output logic [1:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [15:0]   op_data
);
  typedef enum logic [1:0] {M_ARR = 2'd0, M_STS = 2'd1, M_ID = 2'd2, M_CFI = 2'd3} mode_t;
  localparam logic [1:0] K_PROG = 2'd0, K_ERASE = 2'd1, K_LOCK = 2'd2;
  localparam logic [15:0] DEV_CODE = (BLOCK_ARR == 2'd2)
    ? (16'h8999 + 16'(DENSITY_1G))
    : (16'h8960 + 16'(BLOCK_ARR[0]) + 16'(DENSITY_1G) * 16'd2);
  localparam logic [15:0] CFI_SIZE = 16'd26 + 16'(DENSITY_1G);

  mode_t       mode_q;
  logic        pend_q, setup_q;
  logic [1:0]  kind_q;
  logic [3:0]  err_q;
  logic [7:0]  sts_lat;
  logic        ce_q, oe_q, adv_q;

  wire [7:0] cmd      = wdata[7:0];
  wire       data_cyc = bus_we && setup_q;
  wire       vpp_fail = data_cyc && (kind_q != K_LOCK) && !vpp_ok;
  wire       clr      = bus_we && !setup_q && (cmd == 8'h50);
  wire [7:0] sr       = {~wsm_busy, 1'b0, err_q[3], err_q[2], err_q[1], 1'b0, err_q[0], 1'b0};
  wire       cap_async = (ce_q & oe_q) & ~(ce_n & oe_n);
  wire       cap_sync  = (ce_q & ~ce_n) | (adv_q & ~adv_n);
  wire       cap       = burst_mode ? cap_sync : cap_async;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_ARR;
      pend_q   <= 1'b0;
      setup_q  <= 1'b0;
      kind_q   <= K_PROG;
      op_start <= 1'b0;
      op_kind  <= K_PROG;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_start <= 1'b0;
      if (data_cyc) begin
        setup_q <= 1'b0;
        mode_q  <= M_STS;
        if (!vpp_fail) begin
          op_start <= 1'b1;
          op_kind  <= kind_q;
          op_addr  <= addr;
          op_data  <= wdata;
        end
      end else if (bus_we) begin
        case (cmd)
          8'hFF: if (wsm_busy) pend_q <= 1'b1;
                 else begin mode_q <= M_ARR; pend_q <= 1'b0; end
          8'h70: begin mode_q <= M_STS; pend_q <= 1'b0; end
          8'h90: begin mode_q <= M_ID;  pend_q <= 1'b0; end
          8'h98: begin mode_q <= M_CFI; pend_q <= 1'b0; end
          8'h40, 8'h10: if (!wsm_busy) begin setup_q <= 1'b1; kind_q <= K_PROG;  end
          8'h20:        if (!wsm_busy) begin setup_q <= 1'b1; kind_q <= K_ERASE; end
          8'h60:        if (!wsm_busy) begin setup_q <= 1'b1; kind_q <= K_LOCK;  end
          default: ;
        endcase
      end else if (pend_q && !wsm_busy) begin
        mode_q <= M_ARR;
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      sts_lat <= '0;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      adv_q   <= 1'b1;
    end else begin
      err_q   <= (err_q & {4{~clr}}) |
                 {wsm_err_erase, wsm_err_prog, wsm_err_vpp | vpp_fail, wsm_err_lock};
      ce_q    <= ce_n;
      oe_q    <= oe_n;
      adv_q   <= adv_n;
      if (cap) sts_lat <= sr;
    end
  end

  logic [15:0] id_word, cfi_word;
  always_comb begin
    case (addr[7:0])
      8'h00:   id_word = MFR_CODE;
      8'h01:   id_word = DEV_CODE;
      default: id_word = 16'h0000;
    endcase
    case (addr[7:0])
      8'h10:   cfi_word = 16'h0051;
      8'h11:   cfi_word = 16'h0052;
      8'h12:   cfi_word = 16'h0059;
      8'h27:   cfi_word = CFI_SIZE;
      default: cfi_word = 16'h0000;
    endcase
  end

  assign read_mode = mode_q;
  assign dq_out = (mode_q == M_STS) ? {8'h00, sts_lat} :
                  (mode_q == M_ID)  ? id_word :
                  (mode_q == M_CFI) ? cfi_word : array_data;

  // R2
  sts_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode == M_STS |-> (dq_out[15:8] == 8'h00) && !dq_out[6] && !dq_out[2] && !dq_out[0]);
  // R3
  op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  // R3
  op_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> read_mode == M_STS);
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_mode && !(ce_q && !ce_n) && !(adv_q && !adv_n) |=> $stable(sts_lat));
  // R9
  pend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !wsm_busy && !bus_we |=> read_mode == M_ARR);
endmodule

// File: tb/flash_cui_tb_top.sv
module flash_cui_tb_top;
  localparam int PER = 10;
  localparam int AW  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1, burst_mode = 1'b0, vpp_ok = 1'b1;
  logic [15:0] array_data = 16'hA5C3;
  logic wsm_busy = 1'b0, wsm_err_erase = 1'b0, wsm_err_prog = 1'b0;
  logic wsm_err_vpp = 1'b0, wsm_err_lock = 1'b0;
  logic [15:0] dq_out, op_data;
  logic [1:0] read_mode, op_kind;
  logic op_start;
  logic [AW-1:0] op_addr;

  always #(PER/2) clk = ~clk;

  flash_cui #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .addr(addr), .wdata(wdata),
    .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n), .burst_mode(burst_mode),
    .vpp_ok(vpp_ok), .array_data(array_data), .wsm_busy(wsm_busy),
    .wsm_err_erase(wsm_err_erase), .wsm_err_prog(wsm_err_prog),
    .wsm_err_vpp(wsm_err_vpp), .wsm_err_lock(wsm_err_lock),
    .dq_out(dq_out), .read_mode(read_mode), .op_start(op_start),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data));

  typedef struct { int sel; logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  logic req = 1'b0;
  int total = 0, bad = 0, n_ops = 0;
  logic [1:0] last_kind = 2'd3;
  logic done = 1'b0;

  always @(negedge clk) if (op_start) begin n_ops++; last_kind = op_kind; end

  always @(negedge clk) begin
    item_t it;
    logic [15:0] act;
    #(PER/4);
    if (req && sb.size() > 0) begin
      it = sb.pop_front();
      case (it.sel)
        0: act = dq_out;
        1: act = {14'd0, read_mode};
        2: act = 16'(n_ops);
        default: act = {14'd0, last_kind};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int sel, input logic [15:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    req = 1'b1;
    #(PER/2);
    req = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    chk(0, exp, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pins(input logic c, input logic o, input logic v);
    @(negedge clk);
    ce_n = c; oe_n = o; adv_n = v;
  endtask

  task automatic relatch();
    pins(1'b1, 1'b1, 1'b1);
    pins(1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(1, 16'd0, "R1 mode after reset");
    chk(0, 16'hA5C3, "R1 array data after reset");

    wr(24'h123456, 16'h0070);
    chk(1, 16'd1, "R2 status mode at any address");
    relatch();
    chk(0, 16'h0080, "R2 R5 ready status");
    wr(24'h0, 16'h00AB);
    chk(1, 16'd1, "R12 unknown byte ignored");

    wr(24'h0, 16'h0090);
    chk(1, 16'd2, "R10 identifier mode");
    rd(24'h0, 16'h0089, "R10 manufacturer");
    rd(24'h1, 16'h8962, "R10 device code");
    rd(24'h5, 16'h0000, "R10 empty slot");
    wr(24'h0, 16'h0098);
    rd(24'h10, 16'h0051, "R11 query Q");
    rd(24'h12, 16'h0059, "R11 query Y");
    rd(24'h27, 16'h001B, "R11 size byte");
    rd(24'h33, 16'h0000, "R11 empty entry");

    wr(24'h0, 16'h00FF);
    chk(1, 16'd0, "R9 array when idle");
    wr(24'h10, 16'h0040);
    chk(2, 16'd0, "R3 no op after setup");
    wr(24'h2000, 16'hBEEF);
    chk(2, 16'd1, "R3 program starts");
    chk(3, 16'd0, "R3 program kind");
    chk(1, 16'd1, "R3 status after program");
    wr(24'h0, 16'h0020); wr(24'h4000, 16'h00D0);
    chk(3, 16'd1, "R3 erase kind");
    wr(24'h0, 16'h0060); wr(24'h4000, 16'h0001);
    chk(2, 16'd3, "R3 lock starts");
    chk(3, 16'd2, "R3 lock kind");

    vpp_ok = 1'b0;
    wr(24'h0, 16'h0010); wr(24'h8, 16'h1234);
    chk(2, 16'd3, "R4 no op at low vpp");
    relatch();
    chk(0, 16'h0088, "R4 vpp bit set");
    wr(24'h0, 16'h0050);
    chk(1, 16'd1, "R6 clear keeps mode");
    relatch();
    chk(0, 16'h0080, "R6 clear at low vpp");
    vpp_ok = 1'b1;

    @(negedge clk); wsm_err_prog = 1'b1; wsm_err_lock = 1'b1;
    @(negedge clk); wsm_err_prog = 1'b0; wsm_err_lock = 1'b0;
    repeat (4) @(negedge clk);
    relatch();
    chk(0, 16'h0092, "R6 sticky bits");
    wr(24'h0, 16'h0070);
    relatch();
    chk(0, 16'h0092, "R6 status cmd does not clear");

    @(negedge clk); wsm_busy = 1'b1;
    relatch();
    chk(0, 16'h0012, "R5 busy clears bit 7");
    wr(24'h0, 16'h00FF);
    chk(1, 16'd1, "R9 array deferred while busy");
    wr(24'h0, 16'h0040); wr(24'h0, 16'h0001);
    chk(2, 16'd3, "R3 setup ignored while busy");
    @(negedge clk); wsm_busy = 1'b0;
    chk(1, 16'd0, "R9 array after busy ends");

    wr(24'h0, 16'h0070);
    relatch();
    chk(0, 16'h0092, "R7 captured on chip enable fall");
    @(negedge clk); wsm_err_erase = 1'b1;
    @(negedge clk); wsm_err_erase = 1'b0;
    pins(1'b0, 1'b0, 1'b1);
    chk(0, 16'h0092, "R7 second strobe does not recapture");
    pins(1'b1, 1'b1, 1'b1);
    pins(1'b1, 1'b0, 1'b1);
    chk(0, 16'h00B2, "R7 captured on output enable fall");

    @(negedge clk); burst_mode = 1'b1;
    pins(1'b0, 1'b0, 1'b1);
    wr(24'h0, 16'h0050);
    repeat (3) @(negedge clk);
    chk(0, 16'h00B2, "R8 burst holds without toggle");
    pins(1'b0, 1'b0, 1'b0);
    pins(1'b0, 1'b0, 1'b1);
    chk(0, 16'h0080, "R8 address valid refresh");
    @(negedge clk); wsm_err_lock = 1'b1;
    @(negedge clk); wsm_err_lock = 1'b0;
    chk(0, 16'h0080, "R8 hold after new error");
    pins(1'b1, 1'b0, 1'b1);
    pins(1'b0, 1'b0, 1'b1);
    chk(0, 16'h0082, "R8 chip enable refresh");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule